// File: doc/BRIEF.md
# Receive Descriptor Fetch and Write-Back Scheduler

This block decides when a receive DMA engine should pull more descriptors from host memory and when it should return processed descriptors to host memory. It keeps three counts. The first is descriptors held on chip that are valid and not yet used. The second is descriptors that software has made available in host memory. The third is descriptors that have been processed and are waiting to be written back. Processed descriptors keep their on-chip slot until their write-back is acknowledged, so free space is the buffer depth minus both on-chip counts.

Three programmable thresholds control the decisions. A low-water mark on the valid count allows a fetch. A minimum host count is needed before a fetch is issued. A batch size sets when write-back starts. The thresholds are counted either in single descriptors or in cache lines of LINE_DESCS descriptors. An external flush request overrides the batch size. Each request is held with its burst length until the bus side acknowledges it, and the counts move on that acknowledge.

Each request is driven by a small state machine with two states. The fetch machine has F_IDLE and F_WAIT. It takes the transition "issue" (F_IDLE to F_WAIT) when the fetch conditions hold, and "fetch acknowledged" (F_WAIT to F_IDLE) on fetch_ack. The write-back machine has W_IDLE and W_WAIT. It takes "issue" (W_IDLE to W_WAIT) when the batch is full or a flush is pending, and "write-back acknowledged" (W_WAIT to W_IDLE) on wb_ack.

Top module: `rxd_desc_sched`

## Requirements
- R1: After reset, fetch_req and wb_req are low. The mode is per-descriptor, the prefetch and host thresholds are 0, and the write-back threshold is 1, so a single processed descriptor triggers a write-back.
- R2: A fetch is considered only while the valid count is strictly below the effective prefetch threshold. An effective prefetch threshold of 0 disables fetching.
- R3: A fetch is issued only if the host count is at least the effective host threshold. A host threshold that works out to 0 is treated as 1.
- R4: The fetch burst is min(DEPTH - valid - processed, host count), and it is never 0. fetch_req and fetch_len stay unchanged until fetch_ack. On the acknowledge, the valid count grows and the host count shrinks by fetch_len.
- R5: Without a flush, a write-back is issued once the processed count reaches the effective write-back threshold. A threshold of 0 acts as 1. wb_len is the whole processed count at issue. wb_req and wb_len are held until wb_ack, which removes wb_len from the processed count.
- R6: A flush_req pulse forces a write-back of every processed descriptor, whatever the threshold. If it arrives while a write-back is outstanding, it is kept and served after the acknowledge. If nothing is processed and no write-back is outstanding, it is dropped.
- R7: With cfg_line_mode = 1 stored, each clamped threshold is multiplied by LINE_DESCS (16) before comparison.
- R8: Stored thresholds are clamped when used. In per-descriptor mode the maxima are 47 (prefetch), 63 (host) and 63 (write-back). In line mode they are 3, 4 and 3.
- R9: desc_done while the valid count is 0 is ignored and changes no count.
- R10: cfg_wr bit 0 loads cfg_line_mode, bit 1 loads the prefetch threshold, bit 2 the host threshold and bit 3 the write-back threshold. Unselected fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 4 | Per-field configuration load strobes |
| cfg_line_mode | input | 1 | 1 = thresholds in cache lines |
| cfg_pre_thr | input | 6 | Prefetch threshold value |
| cfg_host_thr | input | 6 | Host availability threshold value |
| cfg_wb_thr | input | 6 | Write-back threshold value |
| host_post | input | 1 | Software made descriptors available |
| host_post_num | input | 8 | Number of descriptors made available |
| desc_done | input | 1 | One valid on-chip descriptor was processed |
| flush_req | input | 1 | Force write-back of all processed descriptors |
| fetch_req | output | 1 | Fetch request |
| fetch_len | output | CNT_W (7) | Fetch burst length in descriptors |
| fetch_ack | input | 1 | Fetch completed |
| wb_req | output | 1 | Write-back request |
| wb_len | output | CNT_W (7) | Write-back burst length in descriptors |
| wb_ack | input | 1 | Write-back completed |

## Verification
The bench builds the block with DEPTH 64, LINE_DESCS 16 and HOST_W 12. With these values one fetch in line mode can fill the whole buffer, and a host threshold of 4 lines equals the full buffer depth. This makes the 63-versus-64 host boundary and the exactly-one-line write-back batch reachable with short directed sequences. A long seeded random phase mixes configuration writes, flushes and delayed acknowledges. It compares every output on every cycle with a reference model written from the requirements.

// File: rtl/rxd_sched_pkg.sv
package rxd_sched_pkg;
    localparam int CMP_W = 16;

    typedef enum logic [0:0] {F_IDLE, F_WAIT} fetch_st_e;
    typedef enum logic [0:0] {W_IDLE, W_WAIT} wb_st_e;
endpackage

// File: rtl/rxd_thr_cfg.sv
module rxd_thr_cfg
    import rxd_sched_pkg::*;
#(
    parameter int LINE_DESCS = 16,
    parameter int PRE_MAX_D  = 47,
    parameter int HOST_MAX_D = 63,
    parameter int WB_MAX_D   = 63,
    parameter int PRE_MAX_L  = 3,
    parameter int HOST_MAX_L = 4,
    parameter int WB_MAX_L   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_wr,
    input  logic             cfg_line_mode,
    input  logic [5:0]       cfg_pre_thr,
    input  logic [5:0]       cfg_host_thr,
    input  logic [5:0]       cfg_wb_thr,
    output logic [CMP_W-1:0] pre_eff,
    output logic [CMP_W-1:0] host_eff,
    output logic [CMP_W-1:0] wb_eff
);
    localparam int LINE_SH = $clog2(LINE_DESCS);
    localparam logic [5:0] MAX_D [3] = '{6'(PRE_MAX_D), 6'(HOST_MAX_D), 6'(WB_MAX_D)};
    localparam logic [5:0] MAX_L [3] = '{6'(PRE_MAX_L), 6'(HOST_MAX_L), 6'(WB_MAX_L)};
    localparam logic [5:0] RST_V [3] = '{6'd0, 6'd0, 6'd1};

    logic             line_q;
    logic [5:0]       raw_in [3];
    logic [5:0]       raw_q  [3];
    logic [CMP_W-1:0] eff    [3];

    assign raw_in[0] = cfg_pre_thr;
    assign raw_in[1] = cfg_host_thr;
    assign raw_in[2] = cfg_wb_thr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          line_q <= 1'b0;
        else if (cfg_wr[0])  line_q <= cfg_line_mode;
    end

    for (genvar i = 0; i < 3; i++) begin : g_thr
        logic [5:0]       lim;
        logic [5:0]       clamped;
        logic [CMP_W-1:0] scaled;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             raw_q[i] <= RST_V[i];
            else if (cfg_wr[i+1])   raw_q[i] <= raw_in[i];
        end

        always_comb begin
            lim     = line_q ? MAX_L[i] : MAX_D[i];
            clamped = (raw_q[i] > lim) ? lim : raw_q[i];
            scaled  = line_q ? (CMP_W'(clamped) << LINE_SH) : CMP_W'(clamped);
        end

        if (i == 0) begin : g_plain
            assign eff[i] = scaled;
        end else begin : g_floor
            assign eff[i] = (scaled == '0) ? CMP_W'(1) : scaled;
        end
    end

    assign pre_eff  = eff[0];
    assign host_eff = eff[1];
    assign wb_eff   = eff[2];
endmodule

// File: rtl/rxd_fetch_ctl.sv
module rxd_fetch_ctl
    import rxd_sched_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int HOST_W = 12,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  valid_cnt,
    input  logic [CNT_W-1:0]  ready_cnt,
    input  logic [HOST_W-1:0] host_cnt,
    input  logic [CMP_W-1:0]  pre_eff,
    input  logic [CMP_W-1:0]  host_eff,
    input  logic              fetch_ack,
    output logic              fetch_req,
    output logic [CNT_W-1:0]  fetch_len
);
    fetch_st_e        st_q, st_d;
    logic [CNT_W-1:0] len_q;
    logic [CMP_W-1:0] free_c, host_c, len_c;
    logic             want;

    always_comb begin
        free_c = CMP_W'(DEPTH) - CMP_W'(valid_cnt) - CMP_W'(ready_cnt);
        host_c = CMP_W'(host_cnt);
        want   = (CMP_W'(valid_cnt) < pre_eff) && (host_c >= host_eff) && (free_c != '0);
        len_c  = (free_c < host_c) ? free_c : host_c;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            F_IDLE: if (want)      st_d = F_WAIT;
            F_WAIT: if (fetch_ack) st_d = F_IDLE;
            default:               st_d = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= F_IDLE;
            len_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == F_IDLE && want) len_q <= CNT_W'(len_c);
        end
    end

    always_comb begin
        fetch_req = (st_q == F_WAIT);
        fetch_len = len_q;
    end
endmodule

// File: rtl/rxd_wb_ctl.sv
module rxd_wb_ctl
    import rxd_sched_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] ready_cnt,
    input  logic [CMP_W-1:0] wb_eff,
    input  logic             flush_req,
    input  logic             wb_ack,
    output logic             wb_req,
    output logic [CNT_W-1:0] wb_len
);
    wb_st_e           st_q, st_d;
    logic [CNT_W-1:0] len_q;
    logic             pend_q, pend_d;
    logic             fire;

    assign fire = (ready_cnt != '0) &&
                  ((CMP_W'(ready_cnt) >= wb_eff) || pend_q || flush_req);

    always_comb begin
        st_d   = st_q;
        pend_d = pend_q | flush_req;
        unique case (st_q)
            W_IDLE: begin
                if (fire) begin
                    st_d   = W_WAIT;
                    pend_d = 1'b0;
                end else if (ready_cnt == '0) begin
                    pend_d = 1'b0;
                end
            end
            W_WAIT: if (wb_ack) st_d = W_IDLE;
            default: st_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= W_IDLE;
            len_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
            if (st_q == W_IDLE && fire) len_q <= ready_cnt;
        end
    end

    always_comb begin
        wb_req = (st_q == W_WAIT);
        wb_len = len_q;
    end
endmodule

// File: rtl/rxd_desc_sched.sv
module rxd_desc_sched
    import rxd_sched_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int HOST_W     = 12,
    parameter int LINE_DESCS = 16,
    parameter int PRE_MAX_D  = 47,
    parameter int HOST_MAX_D = 63,
    parameter int WB_MAX_D   = 63,
    parameter int PRE_MAX_L  = 3,
    parameter int HOST_MAX_L = 4,
    parameter int WB_MAX_L   = 3,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_wr,
    input  logic             cfg_line_mode,
    input  logic [5:0]       cfg_pre_thr,
    input  logic [5:0]       cfg_host_thr,
    input  logic [5:0]       cfg_wb_thr,
    input  logic             host_post,
    input  logic [7:0]       host_post_num,
    input  logic             desc_done,
    input  logic             flush_req,
    output logic             fetch_req,
    output logic [CNT_W-1:0] fetch_len,
    input  logic             fetch_ack,
    output logic             wb_req,
    output logic [CNT_W-1:0] wb_len,
    input  logic             wb_ack
);
    logic [CNT_W-1:0]  valid_q, ready_q;
    logic [HOST_W-1:0] host_q;
    logic [CMP_W-1:0]  pre_eff, host_eff, wb_eff;
    logic              take, fdone, wdone;

    rxd_thr_cfg #(
        .LINE_DESCS(LINE_DESCS), .PRE_MAX_D(PRE_MAX_D), .HOST_MAX_D(HOST_MAX_D),
        .WB_MAX_D(WB_MAX_D), .PRE_MAX_L(PRE_MAX_L), .HOST_MAX_L(HOST_MAX_L),
        .WB_MAX_L(WB_MAX_L)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_line_mode(cfg_line_mode),
        .cfg_pre_thr(cfg_pre_thr), .cfg_host_thr(cfg_host_thr), .cfg_wb_thr(cfg_wb_thr),
        .pre_eff(pre_eff), .host_eff(host_eff), .wb_eff(wb_eff)
    );

    rxd_fetch_ctl #(.DEPTH(DEPTH), .HOST_W(HOST_W), .CNT_W(CNT_W)) u_fetch (
        .clk(clk), .rst_n(rst_n), .valid_cnt(valid_q), .ready_cnt(ready_q),
        .host_cnt(host_q), .pre_eff(pre_eff), .host_eff(host_eff),
        .fetch_ack(fetch_ack), .fetch_req(fetch_req), .fetch_len(fetch_len)
    );

    rxd_wb_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_wb (
        .clk(clk), .rst_n(rst_n), .ready_cnt(ready_q), .wb_eff(wb_eff),
        .flush_req(flush_req), .wb_ack(wb_ack), .wb_req(wb_req), .wb_len(wb_len)
    );

    assign take  = desc_done && (valid_q != '0);
    assign fdone = fetch_req && fetch_ack;
    assign wdone = wb_req && wb_ack;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            ready_q <= '0;
            host_q  <= '0;
        end else begin
            valid_q <= valid_q + (fdone ? fetch_len : '0) - CNT_W'(take);
            ready_q <= ready_q - (wdone ? wb_len : '0) + CNT_W'(take);
            host_q  <= host_q + (host_post ? HOST_W'(host_post_num) : '0)
                              - (fdone ? HOST_W'(fetch_len) : '0);
        end
    end
endmodule

// File: rtl/rxd_desc_sched_chk.sv
module rxd_desc_sched_chk #(
    parameter int DEPTH  = 64,
    parameter int HOST_W = 12,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fetch_req,
    input logic [CNT_W-1:0]  fetch_len,
    input logic              fetch_ack,
    input logic              wb_req,
    input logic [CNT_W-1:0]  wb_len,
    input logic              wb_ack,
    input logic [CNT_W-1:0]  valid_q,
    input logic [CNT_W-1:0]  ready_q,
    input logic [HOST_W-1:0] host_q
);
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req && !fetch_ack |=> fetch_req && $stable(fetch_len)); // R4

    AST_FETCH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> fetch_len != '0 && int'(fetch_len) <= int'(host_q) &&
                      int'(valid_q) + int'(ready_q) + int'(fetch_len) <= DEPTH); // R4

    AST_FETCH_NEEDS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fetch_req) |-> $past(host_q) != '0); // R3

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req && $stable(wb_len)); // R5

    AST_WB_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> wb_len != '0 && wb_len <= ready_q); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(valid_q) + int'(ready_q) <= DEPTH); // R9
endmodule

bind rxd_desc_sched rxd_desc_sched_chk #(.DEPTH(DEPTH), .HOST_W(HOST_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_len(fetch_len),
    .fetch_ack(fetch_ack), .wb_req(wb_req), .wb_len(wb_len), .wb_ack(wb_ack),
    .valid_q(valid_q), .ready_q(ready_q), .host_q(host_q)
);

// File: tb/rxd_desc_sched_tb_top.sv
module rxd_desc_sched_tb_top;
    localparam int DEPTH = 64;
    localparam int HOST_W = 12;
    localparam int LINE = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic [3:0]       cfg_wr = '0;
    logic             cfg_line_mode = 1'b0;
    logic [5:0]       cfg_pre_thr = '0, cfg_host_thr = '0, cfg_wb_thr = '0;
    logic             host_post = 1'b0;
    logic [7:0]       host_post_num = '0;
    logic             desc_done = 1'b0, flush_req = 1'b0;
    logic             fetch_ack = 1'b0, wb_ack = 1'b0;
    logic             fetch_req, wb_req;
    logic [CNT_W-1:0] fetch_len, wb_len;

    rxd_desc_sched #(.DEPTH(DEPTH), .HOST_W(HOST_W), .LINE_DESCS(LINE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_line_mode(cfg_line_mode),
        .cfg_pre_thr(cfg_pre_thr), .cfg_host_thr(cfg_host_thr), .cfg_wb_thr(cfg_wb_thr),
        .host_post(host_post), .host_post_num(host_post_num), .desc_done(desc_done),
        .flush_req(flush_req), .fetch_req(fetch_req), .fetch_len(fetch_len),
        .fetch_ack(fetch_ack), .wb_req(wb_req), .wb_len(wb_len), .wb_ack(wb_ack)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // reference model state
    int m_valid = 0, m_ready = 0, m_host = 0;
    bit m_fb = 0, m_wb = 0, m_pend = 0, m_line = 0;
    int m_flen = 0, m_wlen = 0;
    int m_raw [3] = '{0, 0, 1};

    function automatic int eff(int idx);
        int lim, v;
        lim = m_line ? ((idx == 1) ? 4 : 3) : ((idx == 0) ? 47 : 63);
        v = (m_raw[idx] > lim) ? lim : m_raw[idx];
        if (m_line) v = v * LINE;
        if (idx != 0 && v == 0) v = 1;
        return v;
    endfunction

    task automatic chk(bit ok, string msg, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", msg, act, exp);
        end
    endtask

    function automatic void model_step();
        int free, nv, nr, nh, nflen, nwlen;
        bit take, nfb, nwb, npend;
        free = DEPTH - m_valid - m_ready;
        nv = m_valid; nr = m_ready; nh = m_host;
        nfb = m_fb; nwb = m_wb; npend = m_pend; nflen = m_flen; nwlen = m_wlen;
        take = desc_done && (m_valid > 0);
        if (!m_fb) begin
            if (m_valid < eff(0) && m_host >= eff(1) && free > 0) begin
                nfb = 1;
                nflen = (free < m_host) ? free : m_host;
            end
        end else if (fetch_ack) begin
            nfb = 0; nv += m_flen; nh -= m_flen;
        end
        if (take) begin nv -= 1; nr += 1; end
        if (host_post) nh += int'(host_post_num);
        if (!m_wb) begin
            if (m_ready > 0 && (m_ready >= eff(2) || m_pend || flush_req)) begin
                nwb = 1; nwlen = m_ready; npend = 0;
            end else begin
                npend = (m_ready == 0) ? 1'b0 : (m_pend | flush_req);
            end
        end else begin
            npend = m_pend | flush_req;
            if (wb_ack) begin nwb = 0; nr -= m_wlen; end
        end
        if (cfg_wr[0]) m_line = cfg_line_mode;
        if (cfg_wr[1]) m_raw[0] = int'(cfg_pre_thr);
        if (cfg_wr[2]) m_raw[1] = int'(cfg_host_thr);
        if (cfg_wr[3]) m_raw[2] = int'(cfg_wb_thr);
        m_valid = nv; m_ready = nr; m_host = nh;
        m_fb = nfb; m_wb = nwb; m_pend = npend; m_flen = nflen; m_wlen = nwlen;
    endfunction

    task automatic compare(string tag);
        chk(fetch_req == m_fb, {tag, " fetch_req"}, int'(fetch_req), int'(m_fb));
        if (m_fb && fetch_req) chk(int'(fetch_len) == m_flen, {tag, " fetch_len"}, int'(fetch_len), m_flen);
        chk(wb_req == m_wb, {tag, " wb_req"}, int'(wb_req), int'(m_wb));
        if (m_wb && wb_req) chk(int'(wb_len) == m_wlen, {tag, " wb_len"}, int'(wb_len), m_wlen);
    endtask

    task automatic clr();
        cfg_wr = '0; host_post = 0; host_post_num = '0; desc_done = 0;
        flush_req = 0; fetch_ack = 0; wb_ack = 0;
    endtask

    task automatic tick(string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic post(int n, string tag);
        host_post = 1; host_post_num = 8'(n); tick(tag); clr();
    endtask

    task automatic consume(int n, string tag);
        for (int k = 0; k < n; k++) begin desc_done = 1; tick(tag); end
        clr();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset");
        chk(!fetch_req && !wb_req, "R1 no request after reset", int'(fetch_req | wb_req), 0);

        // R9: consume with nothing valid
        consume(1, "R9");
        tick("R9");
        chk(wb_req == 0, "R9 ignored desc_done", int'(wb_req), 0);

        // R10: load prefetch and host only
        cfg_wr = 4'b0110; cfg_pre_thr = 6'd8; cfg_host_thr = 6'd4; tick("R10"); clr();
        post(3, "R3");
        tick("R3"); tick("R3");
        chk(fetch_req == 0, "R3 host below threshold", int'(fetch_req), 0);
        post(1, "R3");
        tick("R3");
        chk(fetch_req == 1 && int'(fetch_len) == 4, "R4 burst min(free,host)", int'(fetch_len), 4);
        tick("R4"); tick("R4");
        chk(fetch_req == 1 && int'(fetch_len) == 4, "R4 held until ack", int'(fetch_len), 4);
        fetch_ack = 1; tick("R4"); clr();

        // R1 / R10: write-back threshold still at its reset value of one
        consume(1, "R1");
        tick("R1");
        chk(wb_req == 1 && int'(wb_len) == 1, "R1 R10 default write-back of one", int'(wb_len), 1);
        wb_ack = 1; tick("R5"); clr();

        // R5: batch of three
        cfg_wr = 4'b1000; cfg_wb_thr = 6'd3; tick("R10"); clr();
        consume(2, "R5");
        tick("R5"); tick("R5");
        chk(wb_req == 0, "R5 below threshold", int'(wb_req), 0);
        consume(1, "R5");
        tick("R5");
        chk(wb_req == 1 && int'(wb_len) == 3, "R5 batch issued", int'(wb_len), 3);
        wb_ack = 1; tick("R5"); clr();

        // R6: flush behaviour
        post(4, "R6");
        tick("R6");
        fetch_ack = 1; tick("R6"); clr();
        consume(1, "R6");
        tick("R6"); tick("R6");
        chk(wb_req == 0, "R6 under threshold before flush", int'(wb_req), 0);
        flush_req = 1; tick("R6"); clr();
        chk(wb_req == 1 && int'(wb_len) == 1, "R6 flush forces write-back", int'(wb_len), 1);
        wb_ack = 1; tick("R6"); clr();
        consume(1, "R6");
        flush_req = 1; tick("R6"); clr();
        desc_done = 1; flush_req = 1; tick("R6"); clr();
        wb_ack = 1; tick("R6"); clr();
        tick("R6");
        chk(wb_req == 1 && int'(wb_len) == 1, "R6 flush kept during busy", int'(wb_len), 1);
        wb_ack = 1; tick("R6"); clr();
        flush_req = 1; tick("R6"); clr();
        tick("R6");
        consume(1, "R6");
        tick("R6"); tick("R6");
        chk(wb_req == 0, "R6 flush with empty queue dropped", int'(wb_req), 0);
        flush_req = 1; tick("R6"); clr();
        wb_ack = 1; tick("R6"); clr();

        // R7 / R8: line mode with clamped thresholds
        cfg_wr = 4'b1111; cfg_line_mode = 1; cfg_pre_thr = 6'd63; cfg_host_thr = 6'd63;
        cfg_wb_thr = 6'd1; tick("R8"); clr();
        post(63, "R8");
        tick("R8"); tick("R8");
        chk(fetch_req == 0, "R7 R8 host 63 below four lines", int'(fetch_req), 0);
        post(1, "R8");
        tick("R7");
        chk(fetch_req == 1 && int'(fetch_len) == 64, "R7 R8 full line-mode fetch", int'(fetch_len), 64);
        fetch_ack = 1; tick("R7"); clr();
        consume(15, "R7");
        tick("R7");
        chk(wb_req == 0, "R7 below one line", int'(wb_req), 0);
        consume(1, "R7");
        tick("R7");
        chk(wb_req == 1 && int'(wb_len) == 16, "R7 one line written back", int'(wb_len), 16);
        wb_ack = 1; tick("R7"); clr();

        // R2 / R3: prefetch low-water mark, host threshold zero acts as one
        cfg_wr = 4'b0100; cfg_host_thr = 6'd0; tick("R3"); clr();
        post(10, "R2");
        tick("R2"); tick("R2");
        chk(fetch_req == 0, "R2 valid equal to prefetch threshold", int'(fetch_req), 0);
        consume(1, "R2");
        tick("R2");
        chk(fetch_req == 1 && int'(fetch_len) == 10, "R2 R3 fetch below threshold", int'(fetch_len), 10);
        fetch_ack = 1; tick("R2"); clr();

        // random phase
        void'($urandom(32'd20240611));
        cfg_wr = 4'b1111; cfg_line_mode = 0; cfg_pre_thr = 6'd20; cfg_host_thr = 6'd2;
        cfg_wb_thr = 6'd4; tick("R10"); clr();
        for (int c = 0; c < 6000; c++) begin
            if ($urandom % 64 == 0) begin
                cfg_wr = 4'($urandom);
                cfg_line_mode = ($urandom % 4 == 0);
                cfg_pre_thr = 6'($urandom);
                cfg_host_thr = 6'($urandom);
                cfg_wb_thr = 6'($urandom);
            end
            if (m_host < 2000 && $urandom % 6 == 0) begin
                host_post = 1; host_post_num = 8'($urandom % 12);
            end
            desc_done = ($urandom % 2 == 0);
            flush_req = ($urandom % 40 == 0);
            fetch_ack = fetch_req && ($urandom % 2 == 0);
            wb_ack = wb_req && ($urandom % 3 == 0);
            tick("R2 R3 R4 R5 R6 R7 R8 random");
            clr();
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule